// File: doc/BRIEF.md
# Stream-to-Memory Packet Writer

This block takes a single packet from a 64-bit valid/ready stream sink and stores it into memory through a write-only memory-mapped master. Each stream beat becomes one 8-byte memory write. Writes start at a destination address loaded by a start pulse and step by 8 bytes per write. The first stream byte of each beat, carried in the top byte of the stream data, is placed in the lowest memory byte lane.

The stream carries start-of-packet, end-of-packet and a 3-bit empty count. The empty count gives the number of unused trailing bytes in the end-of-packet beat. The block trims the final write's byte enables from that count and keeps a saturating byte total.

When the packet ends, the block stops taking beats and lets the last data write drain. It then writes one 32-bit status word to a descriptor address that was also loaded at start. After that word is accepted, it sets completion flags in a status register. An interrupt output is raised for any flag whose enable bit is set.

Top module: `pkt_dma_writer`

## Requirements
- R1: Every beat accepted (st_valid_i and st_ready_o high at a clock edge) produces exactly one memory write. Write data lane i (bits [8i+7:8i]) holds stream byte i, where stream byte 0 sits in st_data_i[63:56] and stream byte 7 in st_data_i[7:0].
- R2: The first write of a packet goes to the destination address loaded at start. Each following write goes to the previous write's address plus 8.
- R3: Every beat without end-of-packet is written with byte enable 8'hFF.
- R4: The end-of-packet beat is written with byte enable 8'hFF shifted right by the empty count. Empty 0 gives 8'hFF, empty 3 gives 8'h1F and empty 7 gives 8'h01.
- R5: Cycles with st_valid_i low inside a packet produce no write and leave the next write address unchanged.
- R6: st_ready_o is low while idle. It is also low from the acceptance of the end-of-packet beat until the descriptor word has been accepted, and never high while desc_write_o is high.
- R7: After the last data write is accepted, exactly one 32-bit descriptor write goes to the descriptor address loaded at start. Its data is {8'h00, 8'h80, byte_count[15:0]}, where 8'h80 is the end-of-packet termination code.
- R8: byte_count is 8 per beat without end-of-packet plus 8 minus empty for the end-of-packet beat. It saturates at 65535.
- R9: Once the descriptor write is accepted, status_o reads 8'h0E: bit 1 means end-of-packet seen, bit 2 means descriptor done and bit 3 means chain done. A start clears status_o to 0. irq_o equals the OR of (status_o & irq_en_i).
- R10: A start in idle loads both addresses and clears the counters. busy_o is high from the cycle after that start until the descriptor write is accepted. A start while busy is ignored.
- R11: While mem_waitreq_i is high with a write pending, the write address, data and byte enable hold stable and no new beat is accepted. While desc_waitreq_i is high, the descriptor write is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| dst_addr_i | input | 32 | Destination byte address of the first data write |
| desc_addr_i | input | 32 | Address for the descriptor status word |
| irq_en_i | input | 8 | Interrupt enable for each status bit |
| busy_o | output | 1 | Packet transfer in progress |
| status_o | output | 8 | Completion flags (8'h0E when done) |
| irq_o | output | 1 | Interrupt request |
| st_valid_i | input | 1 | Stream beat valid |
| st_ready_o | output | 1 | Stream beat ready |
| st_data_i | input | 64 | Stream data, first byte in the top byte |
| st_sop_i | input | 1 | Start of packet (not needed for addressing) |
| st_eop_i | input | 1 | End of packet |
| st_empty_i | input | 3 | Unused trailing bytes on the end-of-packet beat |
| mem_write_o | output | 1 | Data write request |
| mem_addr_o | output | 32 | Data write address |
| mem_wdata_o | output | 64 | Data write data |
| mem_be_o | output | 8 | Data write byte enables |
| mem_waitreq_i | input | 1 | Data write stall |
| desc_write_o | output | 1 | Descriptor write request |
| desc_addr_o | output | 32 | Descriptor write address |
| desc_wdata_o | output | 32 | Descriptor status word |
| desc_waitreq_i | input | 1 | Descriptor write stall |

## Verification
A beat accepted at an edge appears on the memory write port right after that same edge. The bench therefore logs each write at the edge where mem_write_o is high and mem_waitreq_i is low, and compares the log against values computed from the beat index. The descriptor write follows the drain of the last data write. Its completion flags and the fall of busy_o are set at the edge that accepts it, so the bench waits for busy_o to fall at a falling edge before it checks the logs and status_o. Start effects are checked at the falling edge after the start edge, and irq_o is checked just after irq_en_i changes, since it is combinational.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FLUSH, S_WB} pdw_state_e;
  localparam int unsigned DESC_CNT_W   = 16;
  localparam logic [7:0]  DESC_EOP_CODE = 8'h80;
  // bit1 eop seen, bit2 descriptor done, bit3 chain done
  localparam logic [7:0]  STAT_DONE     = 8'h0E;
endpackage

// File: rtl/pdw_lane_fmt.sv
module pdw_lane_fmt #(
  parameter int unsigned DW = 64,
  localparam int unsigned BW = DW / 8,
  localparam int unsigned EW = $clog2(BW)
) (
  input  logic [DW-1:0] data_i,
  input  logic          last_i,
  input  logic [EW-1:0] empty_i,
  output logic [DW-1:0] data_o,
  output logic [BW-1:0] be_o
);
  for (genvar i = 0; i < BW; i++) begin : g_lane
    // stream byte i (from the top) goes to lane i (from the bottom)
    assign data_o[8*i +: 8] = data_i[DW-8-8*i +: 8];
    assign be_o[i] = !last_i || ((32'(i) + 32'(empty_i)) < 32'(BW));
  end
endmodule

// File: rtl/pdw_track.sv
module pdw_track #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 64,
  parameter int unsigned CW = 16,
  localparam int unsigned BW = DW / 8,
  localparam int unsigned EW = $clog2(BW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] desc_i,
  input  logic          beat_i,
  input  logic          last_i,
  input  logic [EW-1:0] empty_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] desc_o,
  output logic [CW-1:0] cnt_o
);
  logic [AW-1:0] addr_q, desc_q;
  logic [CW-1:0] cnt_q, inc;
  logic [CW:0]   sum;

  assign inc = last_i ? (CW'(BW) - CW'(empty_i)) : CW'(BW);
  assign sum = {1'b0, cnt_q} + {1'b0, inc};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      desc_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      addr_q <= dst_i;
      desc_q <= desc_i;
      cnt_q  <= '0;
    end else if (beat_i) begin
      addr_q <= addr_q + AW'(BW);
      cnt_q  <= sum[CW] ? '1 : sum[CW-1:0];
    end
  end

  assign addr_o = addr_q;
  assign desc_o = desc_q;
  assign cnt_o  = cnt_q;

  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i && !load_i |=> addr_q == $past(addr_q) + AW'(BW));
  a_r5_gap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_i && !load_i |=> $stable(addr_q));
  a_r8_cnt_mono: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/pdw_ctrl.sv
module pdw_ctrl
  import pdw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       acc_i,
  input  logic       eop_i,
  input  logic       mem_pend_i,
  input  logic       desc_waitreq_i,
  input  logic [7:0] irq_en_i,
  output logic       run_o,
  output logic       load_o,
  output logic       desc_write_o,
  output logic       busy_o,
  output logic [7:0] status_o,
  output logic       irq_o
);
  pdw_state_e state_q, state_d;
  logic [7:0] status_q;
  logic       wb_done;

  assign load_o  = (state_q == S_IDLE) && start_i;
  assign wb_done = (state_q == S_WB) && !desc_waitreq_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i) state_d = S_RUN;
      S_RUN:   if (acc_i && eop_i) state_d = S_FLUSH;
      S_FLUSH: if (!mem_pend_i) state_d = S_WB;
      S_WB:    if (!desc_waitreq_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      status_q <= '0;
    end else begin
      state_q <= state_d;
      if (load_o)       status_q <= '0;
      else if (wb_done) status_q <= STAT_DONE;
    end
  end

  assign run_o        = state_q == S_RUN;
  assign desc_write_o = state_q == S_WB;
  assign busy_o       = state_q != S_IDLE;
  assign status_o     = status_q;
  assign irq_o        = |(status_q & irq_en_i);

  a_r10_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(desc_write_o && !desc_waitreq_i));
  a_r9_status_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[2]) |-> $past(desc_write_o));
  a_r7_wb_after_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(desc_write_o) |-> $past(!mem_pend_i));
endmodule

// File: rtl/pkt_dma_writer.sv
module pkt_dma_writer
  import pdw_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 64,
  localparam int unsigned BW = DW / 8,
  localparam int unsigned EW = $clog2(BW),
  localparam int unsigned CW = DESC_CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [AW-1:0] desc_addr_i,
  input  logic [7:0]    irq_en_i,
  output logic          busy_o,
  output logic [7:0]    status_o,
  output logic          irq_o,
  input  logic          st_valid_i,
  output logic          st_ready_o,
  input  logic [DW-1:0] st_data_i,
  input  logic          st_sop_i,
  input  logic          st_eop_i,
  input  logic [EW-1:0] st_empty_i,
  output logic          mem_write_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [BW-1:0] mem_be_o,
  input  logic          mem_waitreq_i,
  output logic          desc_write_o,
  output logic [AW-1:0] desc_addr_o,
  output logic [31:0]   desc_wdata_o,
  input  logic          desc_waitreq_i
);
  logic          run, load, acc;
  logic          wr_q;
  logic [AW-1:0] wr_addr_q, cur_addr;
  logic [DW-1:0] wr_data_q, fmt_data;
  logic [BW-1:0] wr_be_q, fmt_be;
  logic [CW-1:0] cnt;
  logic          sop_unused;

  assign sop_unused = st_sop_i;
  assign st_ready_o = run && (!wr_q || !mem_waitreq_i);
  assign acc        = st_valid_i && st_ready_o;

  pdw_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .acc_i          (acc),
    .eop_i          (st_eop_i),
    .mem_pend_i     (wr_q),
    .desc_waitreq_i,
    .irq_en_i,
    .run_o          (run),
    .load_o         (load),
    .desc_write_o,
    .busy_o,
    .status_o,
    .irq_o
  );

  pdw_track #(.AW(AW), .DW(DW), .CW(CW)) u_track (
    .clk_i, .rst_ni,
    .load_i  (load),
    .dst_i   (dst_addr_i),
    .desc_i  (desc_addr_i),
    .beat_i  (acc),
    .last_i  (st_eop_i),
    .empty_i (st_empty_i),
    .addr_o  (cur_addr),
    .desc_o  (desc_addr_o),
    .cnt_o   (cnt)
  );

  pdw_lane_fmt #(.DW(DW)) u_fmt (
    .data_i  (st_data_i),
    .last_i  (st_eop_i),
    .empty_i (st_empty_i),
    .data_o  (fmt_data),
    .be_o    (fmt_be)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      wr_be_q   <= '0;
    end else if (acc) begin
      wr_q      <= 1'b1;
      wr_addr_q <= cur_addr;
      wr_data_q <= fmt_data;
      wr_be_q   <= fmt_be;
    end else if (!mem_waitreq_i) begin
      wr_q <= 1'b0;
    end
  end

  assign mem_write_o  = wr_q;
  assign mem_addr_o   = wr_addr_q;
  assign mem_wdata_o  = wr_data_q;
  assign mem_be_o     = wr_be_q;
  assign desc_wdata_o = {8'h00, DESC_EOP_CODE, cnt};

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_write_o && mem_waitreq_i |=> mem_write_o && $stable(mem_addr_o)
      && $stable(mem_wdata_o) && $stable(mem_be_o));
  a_r11_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_write_o && mem_waitreq_i |-> !st_ready_o);
  a_r1_beat_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i && st_ready_o |=> mem_write_o);
  a_r6_no_ready_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_write_o |-> !st_ready_o);
  a_r4_be_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_write_o |-> mem_be_o[0] && (((mem_be_o + 1'b1) & mem_be_o) == '0));
endmodule

// File: tb/pkt_dma_writer_bench.sv
module pkt_dma_writer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] dst = '0, desc = '0;
  logic [7:0] irq_en = '0;
  logic busy, irq, st_ready, mem_write, desc_write;
  logic [7:0] status;
  logic st_valid = 1'b0, st_sop = 1'b0, st_eop = 1'b0;
  logic [63:0] st_data = '0;
  logic [2:0] st_empty = '0;
  logic [31:0] mem_addr, desc_addr, desc_wdata;
  logic [63:0] mem_wdata;
  logic [7:0] mem_be;
  logic mem_wait = 1'b0, desc_wait = 1'b0;
  bit stall_en = 0;
  int unsigned cyc = 0;

  int tests = 0, fails = 0;
  int wr_n = 0, dw_n = 0, rdy_viol = 0;
  logic [31:0] wr_addr [64];
  logic [63:0] wr_data [64];
  logic [7:0]  wr_be   [64];
  logic [31:0] last_addr, dw_addr, dw_data;

  always #5 clk = ~clk;

  pkt_dma_writer u_pkt_dma_writer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dst_addr_i(dst),
    .desc_addr_i(desc), .irq_en_i(irq_en), .busy_o(busy), .status_o(status),
    .irq_o(irq), .st_valid_i(st_valid), .st_ready_o(st_ready),
    .st_data_i(st_data), .st_sop_i(st_sop), .st_eop_i(st_eop),
    .st_empty_i(st_empty), .mem_write_o(mem_write), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .mem_waitreq_i(mem_wait),
    .desc_write_o(desc_write), .desc_addr_o(desc_addr),
    .desc_wdata_o(desc_wdata), .desc_waitreq_i(desc_wait)
  );

  always @(negedge clk) begin
    cyc++;
    mem_wait  = stall_en && (cyc % 3 != 0);
    desc_wait = stall_en && (cyc % 4 != 0);
  end

  always @(posedge clk) if (rst_n) begin
    if (mem_write && !mem_wait) begin
      if (wr_n < 64) begin
        wr_addr[wr_n] = mem_addr; wr_data[wr_n] = mem_wdata; wr_be[wr_n] = mem_be;
      end
      last_addr = mem_addr;
      wr_n++;
    end
    if (desc_write && !desc_wait) begin
      dw_addr = desc_addr; dw_data = desc_wdata; dw_n++;
    end
    if (desc_write && st_ready) rdy_viol++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic start_pkt(input logic [31:0] d, input logic [31:0] ds);
    @(negedge clk);
    dst = d; desc = ds; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", 64'(busy), 64'd1);
    chk(status == 8'h00, "R9 status cleared by start", 64'(status), 64'd0);
  endtask

  function automatic logic [63:0] beat_data(input int b);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[63-8*k -: 8] = 8'(b*8 + k + 1);
    return v;
  endfunction

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send_beat(input int b, input bit last, input logic [2:0] e);
    st_valid = 1'b1; st_data = beat_data(b); st_sop = (b == 0);
    st_eop = last; st_empty = last ? e : 3'd0;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    st_valid = 1'b0; st_eop = 1'b0; st_sop = 1'b0;
  endtask

  task automatic run_pkt(input string name, input logic [31:0] d, input logic [31:0] ds,
                         input int nb, input logic [2:0] e, input bit gaps, input bit midstart);
    int exp_bytes;
    logic [7:0] exp_be;
    logic [63:0] exp_w;
    wr_n = 0; dw_n = 0; rdy_viol = 0;
    start_pkt(d, ds);
    for (int b = 0; b < nb; b++) begin
      send_beat(b, b == nb - 1, e);
      if (gaps) repeat (b % 3) @(negedge clk);
      if (midstart && b == 1) begin
        dst = 32'h9000_0000; desc = 32'h9100_0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    while (busy) @(negedge clk);
    exp_bytes = 8 * (nb - 1) + 8 - int'(e);
    if (exp_bytes > 65535) exp_bytes = 65535;
    chk(wr_n == nb, {name, " R1 write count"}, 64'(wr_n), 64'(nb));
    chk(last_addr == d + 32'(8 * (nb - 1)), {name, " R2 last address"}, 64'(last_addr),
        64'(d + 32'(8 * (nb - 1))));
    for (int i = 0; i < nb && i < 64; i++) begin
      for (int k = 0; k < 8; k++) exp_w[8*k +: 8] = 8'(i*8 + k + 1);
      exp_be = (i == nb - 1) ? (8'hFF >> e) : 8'hFF;
      chk(wr_addr[i] == d + 32'(8 * i), {name, " R2 address"}, 64'(wr_addr[i]), 64'(d + 32'(8 * i)));
      chk(wr_data[i] == exp_w, {name, " R1 lane order"}, wr_data[i], exp_w);
      chk(wr_be[i] == exp_be, {name, (i == nb - 1) ? " R4 last be" : " R3 full be"},
          64'(wr_be[i]), 64'(exp_be));
    end
    chk(dw_n == 1, {name, " R7 one descriptor write"}, 64'(dw_n), 64'd1);
    chk(dw_addr == ds, {name, " R7 descriptor address"}, 64'(dw_addr), 64'(ds));
    chk(dw_data == {8'h00, 8'h80, 16'(exp_bytes)}, {name, " R8 descriptor word"},
        64'(dw_data), 64'({8'h00, 8'h80, 16'(exp_bytes)}));
    chk(rdy_viol == 0, {name, " R6 ready low during write-back"}, 64'(rdy_viol), 64'd0);
    chk(status == 8'h0E, {name, " R9 status"}, 64'(status), 64'h0E);
    chk(st_ready == 1'b0, {name, " R6 ready low when idle"}, 64'(st_ready), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !st_ready && !mem_write && !desc_write && status == 0, "R6 R10 reset state",
        {busy, st_ready, mem_write, desc_write, status}, 64'd0);

    run_pkt("basic", 32'h0800_F2A8, 32'h0800_F2A4, 5, 3'd0, 0, 0);
    irq_en = 8'h00; #1;
    chk(irq == 1'b0, "R9 irq masked", 64'(irq), 64'd0);
    irq_en = 8'h04; #1;
    chk(irq == 1'b1, "R9 irq enabled", 64'(irq), 64'd1);
    irq_en = 8'h00;

    run_pkt("gaps", 32'h0000_1000, 32'h0000_0F00, 4, 3'd3, 1, 0);
    run_pkt("single", 32'h0000_2000, 32'h0000_0100, 1, 3'd7, 0, 0);
    stall_en = 1;
    run_pkt("stall", 32'h0001_0000, 32'h0000_0200, 6, 3'd5, 1, 0);
    stall_en = 0;
    run_pkt("midstart R10", 32'h0002_0000, 32'h0000_0300, 5, 3'd1, 0, 1);
    run_pkt("saturate", 32'h0010_0000, 32'h0000_0400, 8200, 3'd0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule